// File: doc/BRIEF.md
# Flash Write Qualification Guard

This block sits in front of the command logic of a parallel NOR-style flash model. It watches the asynchronous chip-select, output-enable and write strobes (all active low) through a system clock. It forwards a write only when that write is legitimate. A write cycle runs from the moment both chip-select and write strobe are low until either of them rises. At the end of a qualified cycle the block emits a one-clock pulse carrying the captured address and data.

A write is refused for any of these reasons:
- it lasted fewer sampled clocks than a configured minimum, which filters glitches;
- output-enable was low at any point during it;
- the supply-good input dropped;
- it overlapped the power-on lockout window.

The lockout window starts each time supply-good rises. Two ready flags report when reads may begin (a short delay) and when writes are accepted (a long delay). Every asynchronous input passes through a two-flop synchroniser before any measurement.

Top module: `flash_write_guard`

## Requirements
- R1: While and right after reset, `wr_valid`, `rd_ready` and `wr_ready` are all 0.
- R2: A write cycle whose strobes stay jointly low for fewer than `MIN_LOW_CYC` sampled clocks produces no `wr_valid`. One lasting `MIN_LOW_CYC` or more clocks does produce it.
- R3: Each accepted write cycle produces exactly one `wr_valid` pulse, one clock wide, with `wr_addr` and `wr_data` valid in that same clock.
- R4: The address reported is the one present when the second of chip-select and write strobe went low, whichever strobe fell last.
- R5: The data reported is the one present when the first of chip-select and write strobe went high, whichever strobe rose first.
- R6: A write strobe with chip-select high starts no write. A write cycle during which output-enable is low for any sampled clock is discarded.
- R7: While `vdd_ok` is low, no write is accepted, and `rd_ready` and `wr_ready` stay 0.
- R8: After `vdd_ok` rises, `rd_ready` rises after `RD_DELAY_CYC` clocks and `wr_ready` after `WR_DELAY_CYC` clocks. A write cycle that overlaps any clock before `wr_ready` is discarded, even if it ends after `wr_ready` rises.
- R9: A fall of `vdd_ok` restarts the power-on delay from zero and discards a write cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_ok | input | 1 | Supply above write threshold (asynchronous) |
| ce_n | input | 1 | Chip select, active low (asynchronous) |
| oe_n | input | 1 | Output enable, active low (asynchronous) |
| we_n | input | 1 | Write strobe, active low (asynchronous) |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus write data |
| wr_valid | output | 1 | One-clock pulse for a qualified write |
| wr_addr | output | ADDR_W | Captured write address |
| wr_data | output | DATA_W | Captured write data |
| rd_ready | output | 1 | Read delay after power-up has elapsed |
| wr_ready | output | 1 | Write lockout after power-up has elapsed |

## Verification
The bench builds the guard with a 4-clock minimum strobe width, a 20-clock read delay and a 100-clock write lockout. With these values a full power-up, a write that straddles the end of the lockout, and a supply dropout followed by a complete restart all fit within a few hundred clocks. The 4-clock width lets pulses of 3 and 4 clocks probe the glitch threshold exactly. Staggered strobe edges make each capture point for address and data observable.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  // Control strobe bundle carried through the synchroniser
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic vdd;
  } fwg_ctl_t;

  localparam int CTL_W = $bits(fwg_ctl_t);
endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/fwg_por_timer.sv
module fwg_por_timer #(
  parameter int RD_DELAY_CYC = 25000,
  parameter int WR_DELAY_CYC = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_s,
  output logic rd_ok,
  output logic wr_ok
);
  localparam int CW = $clog2(WR_DELAY_CYC + 1);
  localparam logic [CW-1:0] RD_LIM = CW'(RD_DELAY_CYC);
  localparam logic [CW-1:0] WR_LIM = CW'(WR_DELAY_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !vdd_s) begin
      cnt   <= '0;
      rd_ok <= 1'b0;
      wr_ok <= 1'b0;
    end else begin
      if (cnt != WR_LIM) cnt <= cnt + 1'b1;
      rd_ok <= (cnt >= RD_LIM);
      wr_ok <= (cnt == WR_LIM);
    end
  end
endmodule

// File: rtl/fwg_cycle_tracker.sv
module fwg_cycle_tracker #(
  parameter int MIN_LOW_CYC = 4,
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic              vdd_s,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              valid,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LW-1:0] MIN_LIM = LW'(MIN_LOW_CYC);

  logic          in_wr;
  logic          bad;
  logic [LW-1:0] width;
  logic          cyc;
  logic          veto;

  assign cyc  = ~ce_s & ~we_s;
  assign veto = ~oe_s | ~wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_wr  <= 1'b0;
      bad    <= 1'b0;
      width  <= '0;
      addr_q <= '0;
      data_q <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!vdd_s) begin
        in_wr <= 1'b0;
        bad   <= 1'b0;
        width <= '0;
      end else if (cyc) begin
        if (!in_wr) begin
          in_wr  <= 1'b1;
          width  <= LW'(1);
          bad    <= veto;
          addr_q <= addr_s;
        end else begin
          if (width != MIN_LIM) width <= width + 1'b1;
          bad <= bad | veto;
        end
      end else if (in_wr) begin
        in_wr  <= 1'b0;
        data_q <= data_s;
        valid  <= !bad && (width >= MIN_LIM) && wr_ok && oe_s;
      end
    end
  end
endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 8,
  parameter int MIN_LOW_CYC  = 4,
  parameter int RD_DELAY_CYC = 25000,
  parameter int WR_DELAY_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vdd_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_ready,
  output logic              wr_ready
);
  import fwg_pkg::*;

  localparam int BUS_W = ADDR_W + DATA_W;
  localparam fwg_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, vdd: 1'b0};

  fwg_ctl_t           ctl_raw;
  fwg_ctl_t           ctl_s;
  logic [BUS_W-1:0]   bus_s;

  assign ctl_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, vdd: vdd_ok};

  fwg_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  fwg_sync #(.W(BUS_W), .RST_VAL('0)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({addr, data}),
    .q   (bus_s)
  );

  logic wr_ok;
  logic rd_ok;

  fwg_por_timer #(
    .RD_DELAY_CYC (RD_DELAY_CYC),
    .WR_DELAY_CYC (WR_DELAY_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .vdd_s (ctl_s.vdd),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok)
  );

  fwg_cycle_tracker #(
    .MIN_LOW_CYC (MIN_LOW_CYC),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
  ) u_track (
    .clk    (clk),
    .rst    (rst),
    .ce_s   (ctl_s.ce_n),
    .we_s   (ctl_s.we_n),
    .oe_s   (ctl_s.oe_n),
    .vdd_s  (ctl_s.vdd),
    .wr_ok  (wr_ok),
    .addr_s (bus_s[BUS_W-1:DATA_W]),
    .data_s (bus_s[DATA_W-1:0]),
    .valid  (wr_valid),
    .addr_q (wr_addr),
    .data_q (wr_data)
  );

  assign rd_ready = rd_ok;
  assign wr_ready = wr_ok;
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker (
  input logic clk,
  input logic rst,
  input logic vdd_ok,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic wr_valid,
  input logic rd_ready,
  input logic wr_ready
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R3

  AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_ready); // R8

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> rd_ready); // R8

  AST_NO_SUPPLY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (!vdd_ok && !$past(vdd_ok) && !$past(vdd_ok, 2) && !$past(vdd_ok, 3))
      |-> (!wr_ready && !rd_ready && !wr_valid)); // R7

  AST_VALID_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (!$past(ce_n, 4) && !$past(we_n, 4))); // R2

  AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($past(ce_n, 3) || $past(we_n, 3))); // R5

  AST_OE_HIGH_AT_END: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(oe_n, 4)); // R6
endmodule

bind flash_write_guard fwg_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .vdd_ok   (vdd_ok),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .wr_valid (wr_valid),
  .rd_ready (rd_ready),
  .wr_ready (wr_ready)
);

// File: tb/flash_write_guard_tb.sv
module flash_write_guard_tb;
  localparam int AW  = 18;
  localparam int DW  = 8;
  localparam int MIN = 4;
  localparam int RDD = 20;
  localparam int WRD = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vdd_ok = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_ready;
  logic          wr_ready;

  always #2 clk = ~clk;

  flash_write_guard #(
    .ADDR_W(AW), .DATA_W(DW), .MIN_LOW_CYC(MIN),
    .RD_DELAY_CYC(RDD), .WR_DELAY_CYC(WRD)
  ) u_dut (
    .clk(clk), .rst(rst), .vdd_ok(vdd_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .data(data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_ready(rd_ready),
    .wr_ready(wr_ready)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   spurious = 0;
  logic prev_valid = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a qualified write appears
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid && prev_valid) begin
        checks++; errors++;
        $display("FAIL R3 valid wider than one clock actual=2 expected=1");
      end
      if (wr_valid) begin
        if (q.size() == 0) begin
          spurious++;
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " addr"}, 32'(wr_addr), 32'(e.a));
          check({e.tag, " data"}, 32'(wr_data), 32'(e.d));
        end
      end
      prev_valid <= wr_valid;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: simultaneous strobe write, pushes expectation when accepted
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int low, input bit accept, input string tag);
    if (accept) q.push_back('{a: a, d: d, tag: tag});
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    cycles(low);
    ce_n = 1'b1; we_n = 1'b1;
    cycles(8);
  endtask

  task automatic quiet(input string tag, input int sp0);
    check({tag, " no write emitted"}, 32'(spurious - sp0), 32'd0);
  endtask

  int sp;

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(5);
    check("R1 wr_valid in reset", 32'(wr_valid), 0);
    check("R1 rd_ready in reset", 32'(rd_ready), 0);
    check("R1 wr_ready in reset", 32'(wr_ready), 0);
    rst = 1'b0;
    cycles(2);
    check("R1 wr_ready after reset", 32'(wr_ready), 0);

    // R7: no supply
    sp = spurious;
    wr(18'h00100, 8'h11, 8, 1'b0, "R7");
    quiet("R7", sp);
    check("R7 rd_ready without supply", 32'(rd_ready), 0);
    check("R7 wr_ready without supply", 32'(wr_ready), 0);

    // R8: power-up with a write that straddles the lockout end
    sp = spurious;
    vdd_ok = 1'b1;
    addr = 18'h00222; data = 8'h22; ce_n = 1'b0; we_n = 1'b0;
    cycles(10);
    check("R8 rd_ready early", 32'(rd_ready), 0);
    cycles(20);
    check("R8 rd_ready after read delay", 32'(rd_ready), 1);
    check("R8 wr_ready still locked", 32'(wr_ready), 0);
    cycles(120);
    check("R8 wr_ready after lockout", 32'(wr_ready), 1);
    ce_n = 1'b1; we_n = 1'b1;
    cycles(8);
    quiet("R8 straddling write", sp);

    // R2 / R3: width threshold and normal writes
    sp = spurious;
    wr(18'h00333, 8'h33, MIN - 1, 1'b0, "R2 short");
    quiet("R2 short pulse", sp);
    wr(18'h00444, 8'h44, MIN, 1'b1, "R2 min width");
    wr(18'h3FFFF, 8'hA5, 12, 1'b1, "R3 long");
    wr(18'h15555, 8'h5A, 6, 1'b1, "R3 pattern");

    // R4: address at the later fall, both orders
    q.push_back('{a: 18'h0AAAA, d: 8'h66, tag: "R4 ce last"});
    addr = 18'h01111; data = 8'h66; we_n = 1'b0;
    cycles(3);
    addr = 18'h0AAAA; ce_n = 1'b0;
    cycles(1);
    addr = 18'h02222;
    cycles(6);
    ce_n = 1'b1; we_n = 1'b1;
    cycles(8);
    q.push_back('{a: 18'h0BBBB, d: 8'h77, tag: "R4 we last"});
    addr = 18'h03333; data = 8'h77; ce_n = 1'b0;
    cycles(3);
    addr = 18'h0BBBB; we_n = 1'b0;
    cycles(1);
    addr = 18'h04444;
    cycles(6);
    ce_n = 1'b1; we_n = 1'b1;
    cycles(8);

    // R5: data at the earlier rise, both orders
    q.push_back('{a: 18'h00505, d: 8'hC3, tag: "R5 ce first"});
    addr = 18'h00505; data = 8'hC3; ce_n = 1'b0; we_n = 1'b0;
    cycles(6);
    ce_n = 1'b1;
    cycles(1);
    data = 8'h3C;
    cycles(3);
    we_n = 1'b1;
    cycles(8);
    q.push_back('{a: 18'h00606, d: 8'h81, tag: "R5 we first"});
    addr = 18'h00606; data = 8'h81; ce_n = 1'b0; we_n = 1'b0;
    cycles(6);
    we_n = 1'b1;
    cycles(1);
    data = 8'h18;
    cycles(3);
    ce_n = 1'b1;
    cycles(8);

    // R6: pin inhibit
    sp = spurious;
    addr = 18'h00707; data = 8'h07; ce_n = 1'b0; we_n = 1'b0;
    cycles(3);
    oe_n = 1'b0;
    cycles(1);
    oe_n = 1'b1;
    cycles(4);
    ce_n = 1'b1; we_n = 1'b1;
    cycles(8);
    quiet("R6 oe low mid cycle", sp);
    sp = spurious;
    we_n = 1'b0;
    cycles(8);
    we_n = 1'b1;
    cycles(8);
    quiet("R6 ce high", sp);

    // R9: supply dip during a write
    sp = spurious;
    addr = 18'h00909; data = 8'h99; ce_n = 1'b0; we_n = 1'b0;
    cycles(4);
    vdd_ok = 1'b0;
    cycles(2);
    vdd_ok = 1'b1;
    cycles(4);
    check("R9 wr_ready restarted", 32'(wr_ready), 0);
    cycles(2);
    ce_n = 1'b1; we_n = 1'b1;
    cycles(8);
    quiet("R9 dip discards write", sp);
    cycles(110);
    check("R9 wr_ready after restart", 32'(wr_ready), 1);
    wr(18'h00A0A, 8'hAA, MIN, 1'b1, "R9 after recovery");

    cycles(4);
    check("R3 scoreboard drained", 32'(q.size()), 0);
    check("R3 no unexpected writes", 32'(spurious), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule